// File: doc/BRIEF.md
# Predicated Saturating Vector Shifter

This block takes one vector of signed 32-bit lanes and shifts every lane by its own signed count, taken from the matching lane of a second vector. A count of zero or more shifts the lane left. If the true result no longer fits in 32 signed bits, the lane clamps to the nearest signed limit. A negative count shifts the lane arithmetically right by the count's magnitude.

A per-lane enable mask picks which lanes take the shifted value. Lanes that are masked off pass the first operand through unchanged, so the block can write its result back over that operand. One result vector is registered per accepted input, and a valid strobe marks it one clock later.

The vector width is a parameter, and the lane count is derived from it. The low byte of each count lane, read as a signed value, is the only part of the count that matters.

Top module: `lane_sat_shifter`

## Requirements
- R1: With VEC_W = 128 there are four lanes. Lane i occupies bits [32i+31:32i] of `src_vec`, `cnt_vec` and `res_vec`, and bit i of `lane_en` governs lane i. VEC_W may be 128, 256, 512, 1024 or 2048, and any other value fails elaboration.
- R2: Only bits [7:0] of each count lane set the shift, read as a two's-complement value from -128 to 127. Bits [31:8] have no effect on the result.
- R3: For a count k from 0 to 31, when the lane value times 2^k fits in a signed 32-bit range, the result is exactly that product (a plain left shift).
- R4: A left shift whose true result falls outside the signed 32-bit range gives 0x7FFFFFFF for a non-negative lane and 0x80000000 for a negative lane. Any nonzero lane with a count from 32 to 127 saturates in this way.
- R5: A lane value of zero gives a result of zero for every count.
- R6: A negative count k gives an arithmetic right shift by -k that rounds toward negative infinity. When -k is 32 or more, the result is 0 for a non-negative lane and 0xFFFFFFFF for a negative lane.
- R7: A lane whose `lane_en` bit is 0 outputs its `src_vec` lane unchanged, whatever its count.
- R8: `out_valid` is `in_valid` delayed by exactly one clock, and `res_vec` shows the result of the vector accepted on the previous edge. Back-to-back inputs give back-to-back results.
- R9: While `rst_n` is low, and after it is released until the first accepted vector, `out_valid` is 0 and `res_vec` is all zeros.
- R10: On an edge where `in_valid` is 0, `res_vec` keeps its previous value, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operand vectors are valid this cycle |
| src_vec | input | VEC_W | Lanes to be shifted; also the merge source |
| cnt_vec | input | VEC_W | Per-lane signed shift counts |
| lane_en | input | VEC_W/32 | Per-lane enable; 0 keeps the source lane |
| out_valid | output | 1 | `res_vec` holds a new result |
| res_vec | output | VEC_W | Registered result vector |

## Verification
Every path through a lane ends in the single result register, so a wrong saturation choice, a wrong overflow flag or a wrong right-shift fill shows on `res_vec` in the very cycle `out_valid` rises for that vector. A faulty overflow test is exposed only by values at the edge of the range, such as a product of exactly -2^31 or a count of 31, and the directed vectors aim there. A broken merge or enable path shows as a masked lane that differs from its source. A broken hold or valid pipeline shows one clock later, as a result that changes on an idle edge or a strobe that is misplaced.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
   localparam int unsigned LANE_BITS = 32;
   localparam int unsigned CNT_BITS  = 8;

   function automatic bit legal_vec_width(input int unsigned w);
      return (w == 128) || (w == 256) || (w == 512) || (w == 1024) || (w == 2048);
   endfunction
endpackage

// File: rtl/sat_shift_lane.sv
module sat_shift_lane #(
   parameter int unsigned LANE_W         = 32,
   parameter int unsigned CNT_W          = 8,
   parameter bit          OVF_BY_RESHIFT = 1'b0
) (
   input  logic [LANE_W-1:0] a,
   input  logic [CNT_W-1:0]  cnt,
   output logic [LANE_W-1:0] y
);
   localparam int unsigned SH_W  = $clog2(LANE_W);
   localparam int unsigned EXT_W = 2 * LANE_W;

   if (LANE_W >= (2 ** (CNT_W - 1))) begin : g_bad_cnt
      $error("sat_shift_lane: CNT_W too narrow for LANE_W");
   end

   logic              neg;
   logic [CNT_W-1:0]  mag;
   logic              big;
   logic [SH_W-1:0]   amt;
   logic [LANE_W-1:0] lsh;
   logic              ovf;
   logic [LANE_W-1:0] rsh;
   logic [LANE_W-1:0] sat;

   assign neg = cnt[CNT_W-1];
   assign mag = neg ? CNT_W'(-cnt) : cnt;
   assign big = (mag >= CNT_W'(LANE_W));
   assign amt = mag[SH_W-1:0];
   assign rsh = LANE_W'($signed(a) >>> amt);
   assign sat = a[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};

   if (OVF_BY_RESHIFT) begin : g_ovf_reshift
      // shift back and compare: any lost bit changes the value
      logic [LANE_W-1:0] back;
      assign lsh  = a << amt;
      assign back = LANE_W'($signed(lsh) >>> amt);
      assign ovf  = (back != a);
   end else begin : g_ovf_mask
      // bits pushed out plus new sign must all match the old sign
      logic [EXT_W-1:0]    ext;
      logic [LANE_W:0]     top;
      assign ext = {{LANE_W{a[LANE_W-1]}}, a} << amt;
      assign top = ext[EXT_W-1:LANE_W-1];
      assign lsh = ext[LANE_W-1:0];
      assign ovf = !((&top) || !(|top));
   end

   always_comb begin
      if (neg) begin
         y = big ? {LANE_W{a[LANE_W-1]}} : rsh;
      end else if (a == '0) begin
         y = '0;
      end else if (big || ovf) begin
         y = sat;
      end else begin
         y = lsh;
      end
   end
endmodule

// File: rtl/vshift_stage.sv
module vshift_stage #(
   parameter int unsigned W          = 128,
   parameter bit          RESET_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (RESET_DATA) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/lane_sat_shifter.sv
module lane_sat_shifter #(
   parameter int unsigned VEC_W          = 128,
   parameter bit          OVF_BY_RESHIFT = 1'b0,
   parameter bit          RESET_DATA     = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_valid,
   input  logic [VEC_W-1:0]                       src_vec,
   input  logic [VEC_W-1:0]                       cnt_vec,
   input  logic [VEC_W/sat_shift_pkg::LANE_BITS-1:0] lane_en,
   output logic                                   out_valid,
   output logic [VEC_W-1:0]                       res_vec
);
   import sat_shift_pkg::*;

   localparam int unsigned LW    = LANE_BITS;
   localparam int unsigned CW    = CNT_BITS;
   localparam int unsigned LANES = VEC_W / LW;

   if (!legal_vec_width(VEC_W)) begin : g_bad_width
      $error("lane_sat_shifter: VEC_W must be 128, 256, 512, 1024 or 2048");
   end

   logic [VEC_W-1:0] merged;
   logic             valid_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LW-1:0] shifted;
      logic          cnt_unused;

      assign cnt_unused = ^cnt_vec[i*LW+CW +: LW-CW];

      sat_shift_lane #(
         .LANE_W         (LW),
         .CNT_W          (CW),
         .OVF_BY_RESHIFT (OVF_BY_RESHIFT)
      ) u_lane (
         .a   (src_vec[i*LW +: LW]),
         .cnt (cnt_vec[i*LW +: CW]),
         .y   (shifted)
      );

      assign merged[i*LW +: LW] = lane_en[i] ? shifted : src_vec[i*LW +: LW];

      // R7: masked lane passes its source through
      assert_merge_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !lane_en[i]) |=> (res_vec[i*LW +: LW] == $past(src_vec[i*LW +: LW])));

      // R5: zero lane stays zero
      assert_zero_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && lane_en[i] && (src_vec[i*LW +: LW] == '0)) |=> (res_vec[i*LW +: LW] == '0));

      // R6: right shift keeps the sign
      assert_right_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && lane_en[i] && cnt_vec[i*LW+CW-1])
         |=> (res_vec[i*LW+LW-1] == $past(src_vec[i*LW+LW-1])));

      // R4: left shift, saturated or not, keeps the sign
      assert_left_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && lane_en[i] && !cnt_vec[i*LW+CW-1])
         |=> (res_vec[i*LW+LW-1] == $past(src_vec[i*LW+LW-1])));
   end

   vshift_stage #(
      .W          (VEC_W),
      .RESET_DATA (RESET_DATA)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_valid),
      .d     (merged),
      .q     (res_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= in_valid;
   end

   assign out_valid = valid_q;

   // R8: strobe follows input by one clock
   assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R10: idle edge keeps the result
   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_vec));
endmodule

// File: tb/lane_sat_shifter_tb.sv
module lane_sat_shifter_tb;
   localparam int VEC_W = 128;
   localparam int LANES = 4;

   typedef logic [31:0] quad_t [4];

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [VEC_W-1:0] src_vec = '0;
   logic [VEC_W-1:0] cnt_vec = '0;
   logic [LANES-1:0] lane_en = '0;
   logic             out_valid;
   logic [VEC_W-1:0] res_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   lane_sat_shifter #(.VEC_W(VEC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
      .cnt_vec(cnt_vec), .lane_en(lane_en), .out_valid(out_valid), .res_vec(res_vec)
   );

   function automatic logic [31:0] ref_lane(input logic [31:0] x, input logic [31:0] c);
      int     k;
      longint xv;
      longint p;
      k  = int'($signed(c[7:0]));
      xv = longint'($signed(x));
      if (k >= 0) begin
         if (x == 0) return 32'h0;
         if (k >= 32) return x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
         p = xv * (64'sd1 <<< k);
         if (p > 64'sd2147483647)  return 32'h7FFF_FFFF;
         if (p < -64'sd2147483648) return 32'h8000_0000;
         return p[31:0];
      end
      if (-k >= 32) return {32{x[31]}};
      p = xv >>> (-k);
      return p[31:0];
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input quad_t s, input quad_t c, input logic [3:0] p);
      in_valid = 1'b1;
      lane_en  = p;
      for (int i = 0; i < LANES; i++) begin
         src_vec[i*32 +: 32] = s[i];
         cnt_vec[i*32 +: 32] = c[i];
      end
   endtask

   task automatic expect_lanes(input string tag, input quad_t s, input quad_t c, input logic [3:0] p);
      for (int i = 0; i < LANES; i++) begin
         check($sformatf("%s R1 lane%0d", tag, i), 128'(res_vec[i*32 +: 32]),
               128'(p[i] ? ref_lane(s[i], c[i]) : s[i]));
      end
   endtask

   task automatic run_case(input string tag, input quad_t s, input quad_t c, input logic [3:0] p);
      @(negedge clk);
      drive(s, c, p);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R8 out_valid"}, 128'(out_valid), 128'(1));
      expect_lanes(tag, s, c, p);
   endtask

   task automatic t_reset();
      check("R9 out_valid in reset", 128'(out_valid), 128'(0));
      check("R9 res in reset", res_vec, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 out_valid after release", 128'(out_valid), 128'(0));
      check("R9 res after release", res_vec, '0);
   endtask

   task automatic t_left();
      run_case("R3 basic", '{32'd1, -32'sd3, 32'h1234, 32'd100}, '{32'd4, 32'd2, 32'd0, 32'd10}, 4'hF);
      run_case("R3 edge", '{32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFE},
               '{32'd31, 32'd31, 32'd0, 32'd30}, 4'hF);
   endtask

   task automatic t_saturate();
      run_case("R4 sat", '{32'h4000_0000, 32'hBFFF_FFFF, 32'd5, 32'hC000_0000},
               '{32'd1, 32'd1, 32'd40, 32'd1}, 4'hF);
      run_case("R4 big", '{32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 32'h7FFF_FFFF},
               '{32'd127, 32'd32, 32'd1, 32'd1}, 4'hF);
   endtask

   task automatic t_zero();
      run_case("R5 zero", '{32'd0, 32'd0, 32'd0, 32'd0}, '{32'd127, 32'd31, 32'hFFFF_FFFB, 32'd40}, 4'hF);
   endtask

   task automatic t_right();
      run_case("R6 right", '{32'hFFFF_FFF9, 32'd100, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
               '{32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'hFFFF_FF80, 32'hFFFF_FFE0}, 4'hF);
      run_case("R6 fill", '{32'h8000_0000, 32'h8000_0001, 32'd12345, 32'hFFFF_FF00},
               '{32'hFFFF_FFE1, 32'hFFFF_FFE0, 32'hFFFF_FFF4, 32'hFFFF_FFFC}, 4'hF);
   endtask

   task automatic t_count_bits();
      run_case("R2 low byte", '{32'd3, 32'd64, 32'h7FFF_FFFF, 32'd9},
               '{32'hFFFF_FF01, 32'h0000_00FF, 32'h7FFF_FF80, 32'hABCD_EF00}, 4'hF);
   endtask

   task automatic t_merge();
      run_case("R7 merge", '{32'h1111_1111, 32'h2222_2222, 32'hDEAD_BEEF, 32'h0000_0007},
               '{32'd4, 32'd60, 32'hFFFF_FFF0, 32'd2}, 4'b0101);
      run_case("R7 none", '{32'h8000_0000, 32'd1, 32'd0, 32'h7FFF_FFFF},
               '{32'd5, 32'd5, 32'd5, 32'd5}, 4'b0000);
   endtask

   task automatic t_pipe_hold();
      logic [127:0] held;
      quad_t sa = '{32'd2, 32'd3, 32'd4, 32'd5};
      quad_t sb = '{32'hFFFF_FFF0, 32'd7, 32'h4000_0000, 32'd1};
      quad_t ca = '{32'd1, 32'd1, 32'd1, 32'd1};
      quad_t cb = '{32'hFFFF_FFFE, 32'd3, 32'd2, 32'd0};
      @(negedge clk);
      drive(sa, ca, 4'hF);
      @(negedge clk);
      check("R8 b2b first valid", 128'(out_valid), 128'(1));
      expect_lanes("R8 b2b first", sa, ca, 4'hF);
      drive(sb, cb, 4'hF);
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 b2b second valid", 128'(out_valid), 128'(1));
      expect_lanes("R8 b2b second", sb, cb, 4'hF);
      held    = res_vec;
      src_vec = {4{32'h1357_9BDF}};
      cnt_vec = {4{32'h0000_0003}};
      lane_en = 4'hF;
      @(negedge clk);
      check("R8 idle out_valid", 128'(out_valid), 128'(0));
      check("R10 idle hold", res_vec, held);
      @(negedge clk);
      check("R10 idle hold again", res_vec, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_left();
      t_saturate();
      t_zero();
      t_right();
      t_count_bits();
      t_merge();
      t_pipe_hold();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule